// File: doc/BRIEF.md
# DRAM mode register update sequencer

This block sits on the controller side of a DRAM interface and owns one job: to write a new value into a device mode register without breaking the device timing rules. A client raises a request carrying the target register, the new value, and two flags. The flags say whether nominal on-die termination is enabled in the current settings and whether it is enabled in the new ones. The block keeps the request pending until the device is idle. The device is idle when all banks are precharged, the precharge recovery time has elapsed, no data burst is in flight and the clock enable is high. The block then issues the mode register set command.

After the command, the block fills a programmable settle window with no-operation cycles. If termination was or will be enabled, the block forces the ODT line low. It does this for a configurable number of cycles before the command and keeps it low until the settle window ends. If termination is disabled in both the old and new settings, the ODT line follows the normal ODT request throughout. A single-cycle done pulse marks the end of the window. A new request may be accepted in that same cycle.

Top module: `mrs_seq`

## Requirements
- R1: While reset is asserted and in the first cycles after release, `cmd_o` is NOP (2'b00), `busy_o` and `done_o` are low, and `odt_o` equals `odt_req_i`.
- R2: The mode register set command (`cmd_o` = 2'b01) appears only in a cycle where `banks_idle_i` is high, `burst_busy_i` is low, `cke_i` is high, and at least `trp_cyc_i` cycles have passed since the cycle in which `pre_cmd_i` was high.
- R3: A request accepted while the device is not idle is held, not dropped. The command is issued in the first cycle in which every idle condition and the ODT lead-in are met.
- R4: In the command cycle, `ba_o` carries the latched register select and `addr_o` carries the latched value. In every other cycle both are zero.
- R5: If the command is issued in cycle c, `cmd_o` is NOP in cycles c+1 through c+T, where T is `tmod_cyc_i` sampled at issue, or 1 if that value is 0.
- R6: `busy_o` is high from the cycle after acceptance through cycle c+T-1, and low in cycle c+T.
- R7: When either termination flag is set, `odt_o` is low from the cycle after acceptance through cycle c+T-1. The command comes no earlier than ODT_PRE cycles after the first forced-low cycle.
- R8: When both termination flags are clear, `odt_o` equals `odt_req_i` in every cycle, and a request on an idle device is issued in the first cycle after acceptance.
- R9: `done_o` is high for exactly one cycle, in cycle c+T. `req_ready_o` is high in that cycle, and a request presented then is accepted, so its command can follow in the next cycle.
- R10: A request presented while `req_ready_o` is low is ignored. It produces no command, and the block returns to idle after the done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Update request |
| req_sel_i | input | SEL_W | Target mode register select |
| req_val_i | input | VAL_W | New register value |
| rtt_old_i | input | 1 | Nominal termination enabled in current settings |
| rtt_new_i | input | 1 | Nominal termination enabled in new settings |
| req_ready_o | output | 1 | Request accepted on this cycle if `req_i` is high |
| banks_idle_i | input | 1 | All banks precharged |
| pre_cmd_i | input | 1 | A precharge is issued this cycle |
| burst_busy_i | input | 1 | A data burst is in progress |
| cke_i | input | 1 | Clock enable state |
| odt_req_i | input | 1 | Normal ODT request |
| tmod_cyc_i | input | TMOD_W | Settle window length in cycles |
| trp_cyc_i | input | TRP_W | Precharge recovery time in cycles |
| cmd_o | output | 2 | Command: 00 NOP, 01 mode register set |
| ba_o | output | SEL_W | Register select driven with the command |
| addr_o | output | VAL_W | Value driven with the command |
| odt_o | output | 1 | ODT line |
| busy_o | output | 1 | Update in progress |
| done_o | output | 1 | Settle window complete, single cycle |

## Verification
The done pulse that ends one update and the acceptance of the next request can fall in the same cycle. The bench provokes this by raising a new request exactly in the predicted done cycle. It then expects the next command one cycle later and a second done pulse exactly T cycles after that. A second coincidence is also tested: the precharge recovery expiry or a stall release can land on the same cycle as the end of the ODT lead-in. The bench sweeps stall lengths against gated and ungated requests. It expects the issue cycle at the maximum of the two, computed arithmetically.

// File: rtl/mrs_seq_pkg.sv
package mrs_seq_pkg;
  typedef enum logic [1:0] {
    CMD_NOP = 2'b00,
    CMD_MRS = 2'b01
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_WAIT = 2'b01,
    ST_HOLD = 2'b10
  } st_e;
endpackage

// File: rtl/mrs_dly_cnt.sv
// Down counter: load n, reads zero n cycles later (n=0 treated as 1)
module mrs_dly_cnt #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         zero_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= (val_i == '0) ? '0 : val_i - W'(1);
    else if (cnt_q != '0)      cnt_q <= cnt_q - W'(1);
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/mrs_odt_gate.sv
module mrs_odt_gate #(
  parameter int ODT_PRE = 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic force_i,
  input  logic odt_req_i,
  output logic odt_o,
  output logic lead_ok_o
);
  assign odt_o = force_i ? 1'b0 : odt_req_i;

  generate
    if (ODT_PRE == 0) begin : g_no_lead
      assign lead_ok_o = 1'b1;
    end else begin : g_lead
      localparam int CW = $clog2(ODT_PRE + 1);
      logic [CW-1:0] low_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                     low_q <= '0;
        else if (!force_i)               low_q <= '0;
        else if (low_q < CW'(ODT_PRE))   low_q <= low_q + CW'(1);
      end
      assign lead_ok_o = (low_q >= CW'(ODT_PRE));
    end
  endgenerate
endmodule

// File: rtl/mrs_seq.sv
module mrs_seq
  import mrs_seq_pkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int VAL_W   = 14,
  parameter int TMOD_W  = 5,
  parameter int TRP_W   = 5,
  parameter int ODT_PRE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [SEL_W-1:0]  req_sel_i,
  input  logic [VAL_W-1:0]  req_val_i,
  input  logic              rtt_old_i,
  input  logic              rtt_new_i,
  output logic              req_ready_o,
  input  logic              banks_idle_i,
  input  logic              pre_cmd_i,
  input  logic              burst_busy_i,
  input  logic              cke_i,
  input  logic              odt_req_i,
  input  logic [TMOD_W-1:0] tmod_cyc_i,
  input  logic [TRP_W-1:0]  trp_cyc_i,
  output logic [1:0]        cmd_o,
  output logic [SEL_W-1:0]  ba_o,
  output logic [VAL_W-1:0]  addr_o,
  output logic              odt_o,
  output logic              busy_o,
  output logic              done_o
);
  st_e              st_q, st_d;
  logic [SEL_W-1:0] sel_q;
  logic [VAL_W-1:0] val_q;
  logic             gate_q;
  logic             trp_zero, hold_zero, lead_ok;
  logic             accept, issue, dev_ok, force_low, in_hold_open;

  mrs_dly_cnt #(.W(TRP_W)) u_trp (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (pre_cmd_i),
    .val_i  (trp_cyc_i),
    .zero_o (trp_zero)
  );

  mrs_dly_cnt #(.W(TMOD_W)) u_tmod (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (issue),
    .val_i  (tmod_cyc_i),
    .zero_o (hold_zero)
  );

  mrs_odt_gate #(.ODT_PRE(ODT_PRE)) u_odt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .force_i   (force_low),
    .odt_req_i (odt_req_i),
    .odt_o     (odt_o),
    .lead_ok_o (lead_ok)
  );

  assign dev_ok       = banks_idle_i && !burst_busy_i && cke_i && trp_zero && !pre_cmd_i;
  assign in_hold_open = (st_q == ST_HOLD) && !hold_zero;
  assign done_o       = (st_q == ST_HOLD) && hold_zero;
  assign req_ready_o  = (st_q == ST_IDLE) || done_o;
  assign accept       = req_i && req_ready_o;
  assign issue        = (st_q == ST_WAIT) && dev_ok && (!gate_q || lead_ok);
  assign force_low    = gate_q && ((st_q == ST_WAIT) || in_hold_open);
  assign busy_o       = (st_q == ST_WAIT) || in_hold_open;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (accept) st_d = ST_WAIT;
      ST_WAIT: if (issue)  st_d = ST_HOLD;
      ST_HOLD: if (hold_zero) st_d = accept ? ST_WAIT : ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sel_q  <= '0;
      val_q  <= '0;
      gate_q <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        sel_q  <= req_sel_i;
        val_q  <= req_val_i;
        gate_q <= rtt_old_i | rtt_new_i;
      end
    end
  end

  assign cmd_o  = issue ? CMD_MRS : CMD_NOP;
  assign ba_o   = issue ? sel_q : '0;
  assign addr_o = issue ? val_q : '0;
endmodule

// File: rtl/mrs_seq_chk.sv
module mrs_seq_chk
  import mrs_seq_pkg::*;
#(
  parameter int ODT_PRE = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] cmd_i,
  input logic       odt_i,
  input logic       busy_i,
  input logic       done_i,
  input logic       ready_i,
  input logic       banks_idle_i,
  input logic       burst_busy_i,
  input logic       cke_i,
  input logic       gate_i
);
  p_mrs_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MRS) |-> (banks_idle_i && !burst_busy_i && cke_i));

  p_mrs_odt_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MRS && gate_i) |-> !odt_i);

  p_odt_lead_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MRS && gate_i && (ODT_PRE > 0)) |-> $past(!odt_i));

  p_hold_nop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MRS) |=> (cmd_i == CMD_NOP));

  p_busy_at_mrs_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_i == CMD_MRS) |-> busy_i);

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !done_i);

  p_done_ready_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |-> (ready_i && !busy_i));
endmodule

bind mrs_seq mrs_seq_chk #(.ODT_PRE(ODT_PRE)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_i        (cmd_o),
  .odt_i        (odt_o),
  .busy_i       (busy_o),
  .done_i       (done_o),
  .ready_i      (req_ready_o),
  .banks_idle_i (banks_idle_i),
  .burst_busy_i (burst_busy_i),
  .cke_i        (cke_i),
  .gate_i       (gate_q)
);

// File: tb/mrs_seq_tb_top.sv
`timescale 1ns/1ps
module mrs_seq_tb_top;
  localparam int SEL_W = 3, VAL_W = 14, TMOD_W = 5, TRP_W = 5, ODT_PRE = 1;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_i = 0, rtt_old_i = 0, rtt_new_i = 0, req_ready_o;
  logic [SEL_W-1:0] req_sel_i = '0, ba_o;
  logic [VAL_W-1:0] req_val_i = '0, addr_o;
  logic banks_idle_i = 1, pre_cmd_i = 0, burst_busy_i = 0, cke_i = 1, odt_req_i = 1;
  logic [TMOD_W-1:0] tmod_cyc_i = 5'd2;
  logic [TRP_W-1:0]  trp_cyc_i = 5'd1;
  logic [1:0] cmd_o;
  logic odt_o, busy_o, done_o;
  int errs = 0, checks = 0;

  always #2.5 clk = ~clk;

  mrs_seq #(.SEL_W(SEL_W), .VAL_W(VAL_W), .TMOD_W(TMOD_W), .TRP_W(TRP_W), .ODT_PRE(ODT_PRE)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .req_sel_i(req_sel_i), .req_val_i(req_val_i),
    .rtt_old_i(rtt_old_i), .rtt_new_i(rtt_new_i), .req_ready_o(req_ready_o),
    .banks_idle_i(banks_idle_i), .pre_cmd_i(pre_cmd_i), .burst_busy_i(burst_busy_i),
    .cke_i(cke_i), .odt_req_i(odt_req_i), .tmod_cyc_i(tmod_cyc_i), .trp_cyc_i(trp_cyc_i),
    .cmd_o(cmd_o), .ba_o(ba_o), .addr_o(addr_o), .odt_o(odt_o), .busy_o(busy_o), .done_o(done_o));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // kind: 0 banks busy, 1 burst active, 2 cke low, 3 precharge with trp=stall+1
  task automatic run_case(input int tm, input bit old_f, input bit new_f, input int stall,
                          input int kind, input bit odtv, input bit chain);
    int teff = (tm == 0) ? 1 : tm;
    bit g = old_f | new_f;
    int lead = g ? ODT_PRE : 0;
    int iss = (stall > lead) ? stall : lead;
    int dn = iss + teff;
    logic [SEL_W-1:0] s = SEL_W'(tm + stall + kind);
    logic [VAL_W-1:0] v = VAL_W'(16'h1234 + tm * 37 + stall * 5 + kind);
    @(negedge clk);
    tmod_cyc_i = TMOD_W'(tm);
    trp_cyc_i = TRP_W'(stall + 1);
    pre_cmd_i = (kind == 3);
    req_i = 1; req_sel_i = s; req_val_i = v; rtt_old_i = old_f; rtt_new_i = new_f;
    odt_req_i = odtv;
    #1 chk("R3 ready at request", req_ready_o, 1);
    @(posedge clk);
    for (int k = 0; k <= dn; k++) begin
      @(negedge clk);
      req_i = 0; pre_cmd_i = 0;
      banks_idle_i = !(kind == 0 && k < stall);
      burst_busy_i = (kind == 1 && k < stall);
      cke_i        = !(kind == 2 && k < stall);
      if (k == iss + 1 && k < dn) begin req_i = 1; req_val_i = ~v; end
      if (chain && k == dn) begin
        req_i = 1; rtt_old_i = 0; rtt_new_i = 0; req_sel_i = s ^ 1'b1; req_val_i = v ^ 1'b1;
      end
      #1;
      chk((k == iss) ? "R3 issue cycle" : "R5 nop", cmd_o, (k == iss) ? 1 : 0);
      if (k == iss) begin
        chk("R4 ba", ba_o, s);
        chk("R4 addr", addr_o, v);
      end else chk("R4 addr zero", addr_o, 0);
      if (kind == 3 && k < stall) chk("R2 trp hold", cmd_o, 0);
      chk(g ? "R7 odt" : "R8 odt", odt_o, (g && k < dn) ? 0 : odtv);
      chk("R6 busy", busy_o, k < dn);
      chk("R9 done", done_o, k == dn);
      if (k == iss + 1 && k < dn) chk("R10 not ready", req_ready_o, 0);
      if (chain && k == dn) chk("R9 ready on done", req_ready_o, 1);
    end
    if (chain) begin
      @(negedge clk); req_i = 0; #1;
      chk("R9 chained issue", cmd_o, 1);
      chk("R9 chained addr", addr_o, v ^ 1'b1);
      for (int j = 1; j <= teff; j++) begin
        @(negedge clk); #1;
        chk("R9 chained done", done_o, j == teff);
      end
    end
    for (int j = 0; j < 2; j++) begin
      @(negedge clk); req_i = 0; #1;
      chk("R10 idle cmd", cmd_o, 0);
      chk("R10 idle busy", busy_o, 0);
    end
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #1;
    chk("R1 cmd in reset", cmd_o, 0);
    chk("R1 busy in reset", busy_o, 0);
    chk("R1 done in reset", done_o, 0);
    chk("R1 odt follows", odt_o, 1);
    repeat (3) @(negedge clk);
    rst_ni = 1; odt_req_i = 0;
    @(negedge clk); #1;
    chk("R1 cmd after reset", cmd_o, 0);
    chk("R1 odt follows low", odt_o, 0);
    chk("R1 busy after reset", busy_o, 0);
    for (int tm = 0; tm <= 4; tm++)
      for (int f = 0; f < 4; f++)
        for (int st = 0; st <= 2; st += 2)
          run_case(tm, f[1], f[0], st, (tm + f + st) % 4, bit'(tm % 2), (f == 0 && st == 0));
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule